// File: doc/BRIEF.md
# Burst Address Counter with Repeat

This block produces the internal access address for one port of a synchronous memory. It acts on the rising clock edge and updates the address once per cycle. The new address comes from one of four sources: a freshly strobed external address, the previous address plus one, the previous address unchanged, or the last external address that was strobed in. A host can therefore send one address and then stream a burst of accesses. It can also pause the burst, or jump back to the start of the burst and replay it. None of these moves costs an idle cycle.

All three controls are active low. The repeat control has the highest priority, the address strobe comes next, and the count enable comes last. Both outputs are registered. The address on `int_addr` after an edge is the address used for that cycle's access. `last_addr` holds the most recently strobed external address. The address width is a parameter and defaults to 14 bits, which covers 16K words.

Top module: `burst_addr_gen`

## Requirements
- R1: When `rst_n` is low at a rising edge, both `int_addr` and `last_addr` are zero after that edge.
- R2: With `rpt_n` high and `ads_n` low at an edge, both `int_addr` and `last_addr` take the value of `ext_addr` after that edge.
- R3: With `rpt_n` high, `ads_n` high and `cnt_en_n` low at an edge, `int_addr` becomes its previous value plus one.
- R4: Advancing from the all-ones address gives zero.
- R5: With `rpt_n`, `ads_n` and `cnt_en_n` all high at an edge, `int_addr` keeps its value.
- R6: With `rpt_n` low at an edge, `int_addr` becomes the value `last_addr` held before that edge, whatever the levels of `ads_n` and `cnt_en_n`.
- R7: With `rpt_n` low, a low `ads_n` is ignored: `last_addr` keeps its value and `ext_addr` does not reach `int_addr`.
- R8: `last_addr` changes only at an edge where R2 applies.
- R9: A repeat costs no extra cycle. An advance at the edge right after a repeat edge gives `last_addr` plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_addr | input | ADDR_W | External address, sampled when the strobe is low |
| ads_n | input | 1 | Address strobe, active low |
| cnt_en_n | input | 1 | Count enable, active low |
| rpt_n | input | 1 | Repeat control, active low; returns to the last strobed address |
| int_addr | output | ADDR_W | Internal address for the current cycle |
| last_addr | output | ADDR_W | Last external address loaded by the strobe |

## Verification
The hardest situation to reach is a control combination that arrives while the counter has already drifted away from the saved address. Examples are a repeat with the strobe also low, or an advance right after a repeat. If the stimulus only strobes, these cases show nothing, because the counter and the saved address are still equal. The bench therefore moves the counter away from the saved address first, using a separate load followed by several advances. It then sweeps every control combination against every external value of a 4-bit build. It also walks every start value through a full wrap of the address space.

// File: rtl/burst_addr_pkg.sv
// Shared definitions for the burst address generator.
// Assumes: nothing beyond IEEE 1800-2017.
package burst_addr_pkg;

    // Source of the next internal address.
    typedef enum logic [1:0] {
        SEL_HOLD = 2'd0,
        SEL_LOAD = 2'd1,
        SEL_STEP = 2'd2,
        SEL_RPT  = 2'd3
    } addr_sel_e;

endpackage

// File: rtl/burst_addr_reg.sv
// Width-parameterised register with a load enable and a synchronous
// active-low clear to zero.
// Assumes: a single clock domain; the clear wins over the load.
module burst_addr_reg #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Storage: clear on reset, otherwise capture d when load is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/burst_addr_incr.sv
// Plus-one incrementer built as a ripple of half adders.
// The carry out of the top bit is dropped, so all ones wraps to zero.
// Assumes: W >= 1.
module burst_addr_incr #(
    parameter int W = 14
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);

    logic [W:0] carry;

    // The injected carry is the constant one.
    assign carry[0] = 1'b1;

    // One half adder per bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i]       = a[i] ^ carry[i];
        assign carry[i+1] = a[i] & carry[i];
    end

endmodule

// File: rtl/burst_addr_sel.sv
// Priority decode of the three active-low controls into an address source.
// Priority order: repeat, then strobe, then count enable.
// Assumes: the controls are already synchronous to the clock.
module burst_addr_sel
    import burst_addr_pkg::*;
(
    input  logic      ads_n,
    input  logic      cnt_en_n,
    input  logic      rpt_n,
    output addr_sel_e sel
);

    // Fixed-priority choice of the next source.
    always_comb begin
        if (!rpt_n) begin
            sel = SEL_RPT;
        end else if (!ads_n) begin
            sel = SEL_LOAD;
        end else if (!cnt_en_n) begin
            sel = SEL_STEP;
        end else begin
            sel = SEL_HOLD;
        end
    end

endmodule

// File: rtl/burst_addr_gen.sv
// Per-port burst address generator.
// Each rising edge chooses the next internal address: the strobed
// external address, the previous address plus one, the previous address,
// or the last strobed address (repeat). The saved copy of the last
// strobed address changes only on a strobe that is not overridden by
// repeat.
// Assumes: a single clock; synchronous active-low reset clears everything.
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              ads_n,
    input  logic              cnt_en_n,
    input  logic              rpt_n,
    output logic [ADDR_W-1:0] int_addr,
    output logic [ADDR_W-1:0] last_addr
);

    addr_sel_e          sel;
    logic [ADDR_W-1:0]  addr_plus1;
    logic [ADDR_W-1:0]  addr_next;
    logic               save_ext;

    burst_addr_sel u_sel (
        .ads_n    (ads_n),
        .cnt_en_n (cnt_en_n),
        .rpt_n    (rpt_n),
        .sel      (sel)
    );

    burst_addr_incr #(.W(ADDR_W)) u_incr (
        .a (int_addr),
        .y (addr_plus1)
    );

    // Next-address multiplexer driven by the decoded source.
    always_comb begin
        unique case (sel)
            SEL_LOAD: addr_next = ext_addr;
            SEL_STEP: addr_next = addr_plus1;
            SEL_RPT:  addr_next = last_addr;
            default:  addr_next = int_addr;
        endcase
    end

    // The saved address follows only a strobe that repeat does not override.
    assign save_ext = (sel == SEL_LOAD);

    burst_addr_reg #(.W(ADDR_W)) u_int_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (1'b1),
        .d     (addr_next),
        .q     (int_addr)
    );

    burst_addr_reg #(.W(ADDR_W)) u_last_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (save_ext),
        .d     (ext_addr),
        .q     (last_addr)
    );

endmodule

// File: rtl/burst_addr_gen_chk.sv
// Port-level checker for burst_addr_gen, attached with bind.
// Assumes: it samples the same clock as the generator.
module burst_addr_gen_chk #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              ads_n,
    input logic              cnt_en_n,
    input logic              rpt_n,
    input logic [ADDR_W-1:0] int_addr,
    input logic [ADDR_W-1:0] last_addr
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    // Reset clears both outputs.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (int_addr == '0 && last_addr == '0));

    // A strobe that repeat does not override loads both outputs.
    p_load_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_n && !ads_n) |=> (int_addr == $past(ext_addr) && last_addr == $past(ext_addr)));

    // Count enable alone advances by one, wrapping at the top.
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_n && ads_n && !cnt_en_n) |=> (int_addr == $past(int_addr) + ONE));

    // With every control idle the address holds.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_n && ads_n && cnt_en_n) |=> $stable(int_addr));

    // Repeat restores the saved address.
    p_repeat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rpt_n |=> (int_addr == $past(last_addr)));

    // The saved address moves only on an effective strobe (R7, R8).
    p_last_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rpt_n || ads_n) |=> $stable(last_addr));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_addr  (ext_addr),
    .ads_n     (ads_n),
    .cnt_en_n  (cnt_en_n),
    .rpt_n     (rpt_n),
    .int_addr  (int_addr),
    .last_addr (last_addr)
);

// File: tb/burst_addr_gen_tb_top.sv
// Self-checking bench: sweeps a 4-bit build exhaustively against an
// arithmetic model of the address rules.
module burst_addr_gen_tb_top;

    localparam int AW = 4;
    localparam int SPAN = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          ads_n = 1'b1;
    logic          cnt_en_n = 1'b1;
    logic          rpt_n = 1'b1;
    logic [AW-1:0] int_addr;
    logic [AW-1:0] last_addr;

    logic [AW-1:0] exp_int = '0;
    logic [AW-1:0] exp_last = '0;
    int            n_checks = 0;
    int            n_fails = 0;

    // 250 MHz clock.
    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_addr  (ext_addr),
        .ads_n     (ads_n),
        .cnt_en_n  (cnt_en_n),
        .rpt_n     (rpt_n),
        .int_addr  (int_addr),
        .last_addr (last_addr)
    );

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Apply one cycle of controls, update the model and check both outputs.
    task automatic cyc(input logic a_n, input logic c_n, input logic r_n, input logic [AW-1:0] e);
        string rq_i;
        string rq_l;
        ads_n = a_n; cnt_en_n = c_n; rpt_n = r_n; ext_addr = e;
        @(posedge clk);
        if (!r_n) begin
            exp_int = exp_last;
            rq_i = a_n ? "R6" : "R7";
            rq_l = a_n ? "R8" : "R7";
        end else if (!a_n) begin
            exp_int = e; exp_last = e;
            rq_i = "R2"; rq_l = "R2";
        end else if (!c_n) begin
            rq_i = (exp_int == '1) ? "R4" : "R3";
            exp_int = exp_int + 4'd1;
            rq_l = "R8";
        end else begin
            rq_i = "R5"; rq_l = "R8";
        end
        @(negedge clk);
        check(rq_i, int_addr, exp_int);
        check(rq_l, last_addr, exp_last);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        // R1: reset clears both outputs.
        ext_addr = 4'h9; ads_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", int_addr, '0);
        check("R1", last_addr, '0);
        rst_n = 1'b1;

        // Exhaustive sweep: move the counter away from the saved address,
        // then apply each control combination with each external value.
        for (int e = 0; e < SPAN; e++) begin
            for (int c = 0; c < 8; c++) begin
                cyc(1'b0, 1'b1, 1'b1, AW'((e * 5 + 3) % SPAN));
                cyc(1'b1, 1'b0, 1'b1, '0);
                cyc(1'b1, 1'b0, 1'b1, '0);
                cyc(c[0], c[1], c[2], AW'(e));
            end
        end

        // R4: every start value walked through a full wrap.
        for (int s = 0; s < SPAN; s++) begin
            cyc(1'b0, 1'b1, 1'b1, AW'(s));
            for (int k = 0; k < SPAN; k++) cyc(1'b1, 1'b0, 1'b1, '0);
        end

        // R9: repeat immediately followed by an advance, no idle cycle.
        cyc(1'b0, 1'b1, 1'b1, 4'hC);
        cyc(1'b1, 1'b0, 1'b1, '0);
        cyc(1'b1, 1'b0, 1'b1, '0);
        cyc(1'b1, 1'b1, 1'b0, '0);
        ads_n = 1'b1; cnt_en_n = 1'b0; rpt_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R9", int_addr, 4'hD);
        exp_int = 4'hD;

        // R1: reset in the middle of a burst.
        cyc(1'b0, 1'b1, 1'b1, 4'h7);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", int_addr, '0);
        check("R1", last_addr, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule